// File: doc/BRIEF.md
# Frame-Synchronised Full-Duplex Serial Converter Port

This block is the digital serial port of a combined analog-to-digital and digital-to-analog converter. One bit clock and a frame pulse together set the sampling rate and the word length. The frame pulse rises once per sample period, and the number of clock cycles between two rises is the length of the serial word. In every frame the port sends out the conversion result that the converter hands over at the frame start, and it collects the next DAC sample from the serial input. Both serial lines carry the most significant bit first. The exchange is full duplex.

A received word is handed to the DAC side at the start of the following frame. It is offered in two forms. One is a parallel word, left-aligned to the converter width. The other is a serial stream with the least significant bit first, which is the order the converter consumes it in. At the same frame boundary the port issues a one-cycle strobe. The strobe starts the next conversion and updates the DAC track stage.

Top module: `codec_serial_port`

## Requirements
- R1: While reset is held and until the first frame pulse, `sdo_o`, `frame_strobe_o`, `dac_word_o`, `frame_len_o` and `dac_bit_vld_o` are all 0. Serial input received before the first frame pulse is ignored.
- R2: `frame_strobe_o` is high for exactly one cycle, in the cycle after the rising clock edge at which `sync_i` is first seen high following a low. Holding `sync_i` high for several cycles gives one strobe only.
- R3: `sdi_i` is sampled on rising edges. The bit sampled at the frame-start edge is the most significant bit of the new word. At the next frame-start edge, `dac_word_o` takes that frame's word and holds it until the following frame start. The first frame start after reset yields 0.
- R4: A frame with fewer bits than `DAC_W` is left-aligned in `dac_word_o`, with zeros in the unused low bits.
- R5: Only the first `MAX_BITS` (15) bits of a frame are collected, and later bits are ignored. Of the collected bits, the first `DAC_W` bits form `dac_word_o`.
- R6: `frame_len_o` gives the number of clock cycles between the last two frame starts, capped at `MAX_BITS`. It changes only together with the strobe.
- R7: `adc_word_i` is captured at the frame-start edge. Its bits are then driven on `sdo_o`, most significant bit first, one bit per falling edge. The MSB appears at the falling edge that follows the frame-start edge, so a receiver can sample each bit on the next rising edge.
- R8: After all `ADC_W` bits of a frame have been sent, `sdo_o` stays 0 until the next frame start.
- R9: Starting in the strobe cycle, `dac_bit_o` gives the new `dac_word_o` least significant bit first, one bit per cycle, with `dac_bit_vld_o` high for `DAC_W` cycles. A new frame start restarts the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame pulse; a rise marks the first bit of a frame |
| sdi_i | input | 1 | Serial DAC data in, MSB first |
| adc_word_i | input | ADC_W | Conversion result to send in the starting frame |
| sdo_o | output | 1 | Serial ADC data out, MSB first, changes on falling edges |
| frame_strobe_o | output | 1 | One-cycle start-of-conversion and DAC-update strobe |
| dac_word_o | output | DAC_W | Last complete received word, left-aligned |
| frame_len_o | output | $clog2(MAX_BITS+1) | Length of the last complete frame, capped |
| dac_bit_o | output | 1 | DAC word stream, LSB first |
| dac_bit_vld_o | output | 1 | Marks valid bits on `dac_bit_o` |

## Verification
The bench builds the port with the default widths: 14-bit ADC and DAC words and a 15-bit cap. With these widths, frames of 3, 8, 14, 15 and 20 bits exercise several cases. They cover zero-filling and a DAC stream cut short by the next frame. They cover dropping the single bit past the converter width and ignoring the bits past the cap. A frame pulse held for three cycles and serial input driven before the first pulse test the edge detection and the start-up state.

// File: rtl/codec_serial_port.sv
module codec_serial_port #(
  parameter int ADC_W    = 14,
  parameter int DAC_W    = 14,
  parameter int MAX_BITS = 15,
  localparam int CW      = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             sdi_i,
  input  logic [ADC_W-1:0] adc_word_i,
  output logic             sdo_o,
  output logic             frame_strobe_o,
  output logic [DAC_W-1:0] dac_word_o,
  output logic [CW-1:0]    frame_len_o,
  output logic             dac_bit_o,
  output logic             dac_bit_vld_o
);

  localparam int DCW = $clog2(DAC_W + 1);
  localparam logic [CW-1:0]  CAP   = CW'(MAX_BITS);
  localparam logic [DCW-1:0] DFULL = DCW'(DAC_W);

  logic                      sync_q;
  logic                      started;
  logic [MAX_BITS-1:0]       acc;
  logic [CW-1:0]             cnt;
  logic [ADC_W-1:0]          tx_sh;
  logic [DAC_W-1:0]          dac_ser;
  logic [DCW-1:0]            dac_left;
  logic [MAX_BITS+DAC_W-1:0] wide;
  logic [DAC_W-1:0]          aligned;
  logic                      rise;

  assign rise    = sync_i & ~sync_q;
  assign wide    = {acc, {DAC_W{1'b0}}} >> cnt;
  assign aligned = wide[DAC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      started <= 1'b0;
      acc     <= '0;
      cnt     <= '0;
    end else begin
      sync_q <= sync_i;
      if (rise) begin
        started <= 1'b1;
        acc     <= {{(MAX_BITS-1){1'b0}}, sdi_i};
        cnt     <= CW'(1);
      end else if (started && cnt != CAP) begin
        acc <= {acc[MAX_BITS-2:0], sdi_i};
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_strobe_o <= 1'b0;
      dac_word_o     <= '0;
      frame_len_o    <= '0;
    end else begin
      frame_strobe_o <= rise;
      if (rise) begin
        dac_word_o  <= aligned;
        frame_len_o <= cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tx_sh <= '0;
    else if (rise) tx_sh <= adc_word_i;
    else           tx_sh <= {tx_sh[ADC_W-2:0], 1'b0};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sdo_o <= 1'b0;
    else        sdo_o <= tx_sh[ADC_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_ser  <= '0;
      dac_left <= '0;
    end else if (rise) begin
      dac_ser  <= aligned;
      dac_left <= DFULL;
    end else if (dac_left != '0) begin
      dac_ser  <= dac_ser >> 1;
      dac_left <= dac_left - 1'b1;
    end
  end

  assign dac_bit_o     = dac_ser[0];
  assign dac_bit_vld_o = (dac_left != '0);

  p_strobe_needs_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe_o |-> $past(sync_i));
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe_o |=> !frame_strobe_o);
  p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe_o |-> $stable(dac_word_o));
  p_len_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe_o |-> $stable(frame_len_o));
  p_stream_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe_o |-> (dac_bit_vld_o && dac_bit_o == dac_word_o[0]));

endmodule

// File: tb/codec_serial_port_bench.sv
module codec_serial_port_bench;
  localparam int AW = 14;
  localparam int DW = 14;
  localparam int MB = 15;
  localparam int CW = $clog2(MB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0;
  logic sdi_i = 1'b0;
  logic [AW-1:0] adc_word_i = '0;
  logic sdo_o, frame_strobe_o, dac_bit_o, dac_bit_vld_o;
  logic [DW-1:0] dac_word_o;
  logic [CW-1:0] frame_len_o;

  always #5 clk = ~clk;

  codec_serial_port #(.ADC_W(AW), .DAC_W(DW), .MAX_BITS(MB)) u_codec_serial_port (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .sdi_i(sdi_i), .adc_word_i(adc_word_i),
    .sdo_o(sdo_o), .frame_strobe_o(frame_strobe_o), .dac_word_o(dac_word_o),
    .frame_len_o(frame_len_o), .dac_bit_o(dac_bit_o), .dac_bit_vld_o(dac_bit_vld_o));

  int nchk = 0, nfail = 0;
  logic [DW-1:0] exp_word_q[$];
  int            exp_len_q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // driver state
  int prev_len = 0;
  logic [31:0] prev_pat = '0;
  logic [AW-1:0] cur_adc = '0;
  bit started = 0;
  int tx_j = 0;
  bit pend_v = 0;
  logic pend = 1'b0;

  function automatic logic [DW-1:0] expect_word(input int len, input logic [31:0] pat);
    logic [DW-1:0] w = '0;
    int eff = (len > MB) ? MB : len;
    for (int i = 0; i < DW; i++)
      if (i < eff) w[DW-1-i] = pat[len-1-i];
    return w;
  endfunction

  task automatic tick(input logic s, input logic d, input bit first, input logic [AW-1:0] adc);
    @(negedge clk);
    #2;
    if (pend_v)
      chk(sdo_o === pend, (tx_j > AW || !started) ? "R8 sdo quiet" : "R7 sdo bit", sdo_o, pend);
    sync_i = s;
    sdi_i = d;
    adc_word_i = adc;
    if (first) begin
      tx_j = 0;
      cur_adc = adc;
      started = 1;
    end
    pend = (started && tx_j < AW) ? cur_adc[AW-1-tx_j] : 1'b0;
    pend_v = 1;
    tx_j++;
  endtask

  task automatic send_frame(input int len, input int hold, input logic [31:0] pat,
                            input logic [AW-1:0] adc);
    for (int j = 0; j < len; j++) begin
      if (j == 0) begin
        exp_word_q.push_back(expect_word(prev_len, prev_pat));
        exp_len_q.push_back((prev_len > MB) ? MB : prev_len);
      end
      tick(j < hold, pat[len-1-j], j == 0, adc);
    end
    prev_len = len;
    prev_pat = pat;
  endtask

  task automatic idle(input int n, input logic d);
    for (int j = 0; j < n; j++) tick(1'b0, d, 1'b0, adc_word_i);
  endtask

  // monitor / scoreboard
  logic [DW-1:0] cur_word = '0;
  bit act = 0;
  int pos = 0;
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (frame_strobe_o) begin
          if (exp_word_q.size() == 0) chk(1'b0, "R2 unexpected strobe", 1, 0);
          else begin
            logic [DW-1:0] ew;
            int el;
            ew = exp_word_q.pop_front();
            el = exp_len_q.pop_front();
            chk(dac_word_o === ew, (el < DW) ? "R4 word zero-fill" :
                (el > DW) ? "R5 word truncate" : "R3 word", dac_word_o, ew);
            chk(frame_len_o == CW'(el), "R6 frame length", frame_len_o, el);
            cur_word = ew;
            act = 1;
            pos = 0;
          end
        end
        if (act) begin
          chk(dac_bit_vld_o === (pos < DW), "R9 stream valid", dac_bit_vld_o, pos < DW);
          if (pos < DW) chk(dac_bit_o === cur_word[pos], "R9 stream bit", dac_bit_o, cur_word[pos]);
          pos++;
        end
      end
    end
  end

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({sdo_o, frame_strobe_o, dac_bit_vld_o} == 3'b000, "R1 reset flags",
        {sdo_o, frame_strobe_o, dac_bit_vld_o}, 0);
    chk(dac_word_o == '0 && frame_len_o == '0, "R1 reset word/len", dac_word_o, 0);
    rst_n = 1'b1;
    idle(6, 1'b1);
    chk(frame_strobe_o == 1'b0 && dac_bit_vld_o == 1'b0, "R1 idle before sync",
        {frame_strobe_o, dac_bit_vld_o}, 0);
    send_frame(14, 1, 32'h2A5C, 14'h1234);
    send_frame(14, 1, 32'h1F0F, 14'h3ABC);
    send_frame(8, 1, 32'hB7, 14'h2001);
    send_frame(15, 1, 32'h6AD5, 14'h0FFF);
    send_frame(20, 1, 32'hC3A5F, 14'h2AAA);
    send_frame(14, 3, 32'h3C3C, 14'h1555);
    send_frame(3, 1, 32'h5, 14'h3FFF);
    send_frame(14, 1, 32'h0C0D, 14'h0001);
    send_frame(1, 1, 32'h1, 14'h2000);
    idle(20, 1'b0);
    chk(exp_word_q.size() == 0, "R2 strobe count", exp_word_q.size(), 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule